// File: doc/BRIEF.md
# Packet Page Allocator and Queue Manager

This block looks after a small pool of equal-sized packet pages for a network controller. A host-side command register issues 3-bit codes. These codes claim pages for outgoing frames, give pages back, move page numbers through three queues, and wipe the allocator state. The three queues hold pages waiting to be sent, pages whose transmission has finished, and pages holding received frames. A frame writer on the receive side asks for pages through its own request line. A masked interrupt status byte sums up what happened and drives one interrupt line.

The frame transmitter itself is outside the block. When sending is enabled, the block takes pages from the transmit queue in arrival order. For each page it gives a one-cycle start pulse together with the page number. The page is then either freed at once or recorded in the completion queue, depending on the auto-release input. If a transmit allocation finds no free page, the request stays pending and is served without further commands once a page comes free. Queue heads read 0x80 when their queue is empty.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset, usedPages is 0, allocResult is 0, doneHead and rxHead both read 0x80, intStatus is 0x04, intMask is 0, irq is low and txStart is low.
- R2: Command code 1 (allocate for transmit) takes the lowest-numbered free page. It marks the page used, shows the page index in allocResult, and sets interrupt bit 3 (0x08, allocation).
- R3: When every page is in use, code 1 puts 0x80 in allocResult, clears bit 3 and leaves the request pending. A later release lets the pending request take the freed page in the first command-free cycle after the release, and bit 3 is then set again.
- R4: Code 2 frees every page, empties all three queues, drops a pending allocation and writes 0 to allocResult.
- R5: A rxAllocReq is granted (rxAccept high) in a cycle that meets all of these conditions: no command is strobed, no pending allocation is being served, a page is free, and the receive queue is not full. The lowest free page is then marked used and appended to the receive queue, and bit 0 (0x01, receive) is set.
- R6: Code 3 removes the head of the receive queue. Code 4 removes the head and also frees that page. After either one, bit 0 is 1 if entries remain and 0 if the queue is empty. Either code on an empty receive queue changes no page and no queue.
- R7: Code 5 frees the page given on pktNum. Code 6 appends pktNum to the transmit queue, which holds NUM_PAGES entries. An append to a full transmit queue is ignored.
- R8: While txEnable is high, each queued page produces one txStart pulse with its number on txPage, in queue order, one page per cycle. While txEnable is low, no pulse is produced.
- R9: A sent page is freed if autoRelease is high. Otherwise its number is appended to the completion queue, whose head shows on doneHead. It is dropped if that queue already holds NUM_PAGES entries.
- R10: Code 7 empties both the transmit queue and the completion queue. No page is issued in that cycle.
- R11: Status bit 2 (0x04) is set in every cycle in which the transmit queue is empty. Bit 1 (0x02) is set in every cycle in which the completion queue is not empty. Both bits stay set until they are acknowledged.
- R12: An acknowledge clears only the status bits in ackData AND 0xD6, so bits 0, 3 and 5 are not affected. Acknowledging bit 1 also removes the head of the completion queue.
- R13: maskWe loads intMask from maskData, and irq is high exactly when intStatus AND intMask is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command code (0 to 7) |
| pktNum | input | PAGE_W | Page number used by codes 5 and 6 |
| rxAllocReq | input | 1 | Frame writer asks for a receive page |
| rxAccept | output | 1 | Receive page granted this cycle |
| txEnable | input | 1 | Allows queued pages to be issued |
| autoRelease | input | 1 | Free pages once sent instead of recording them |
| ackValid | input | 1 | Interrupt acknowledge strobe |
| ackData | input | 8 | Status bits to acknowledge |
| maskWe | input | 1 | Interrupt mask write strobe |
| maskData | input | 8 | New interrupt mask |
| allocResult | output | 8 | Last transmit allocation result, 0x80 on failure |
| doneHead | output | 8 | Completion queue head, 0x80 when empty |
| rxHead | output | 8 | Receive queue head, 0x80 when empty |
| usedPages | output | CNT_W | Number of allocated pages |
| intStatus | output | 8 | Interrupt status byte |
| intMask | output | 8 | Interrupt mask byte |
| irq | output | 1 | Interrupt line |
| txStart | output | 1 | One-cycle pulse per page issued |
| txPage | output | PAGE_W | Page number issued with txStart |

## Verification
The bench fills the pool and asks for one more page. If the pending request were lost, allocResult would stay at 0x80 after the release, and if the pending retry went wrong it would come back with a page other than the one just freed. It pushes a fifth page into a full transmit queue and then a fifth completion into a full completion queue. A design that wrapped or overwrote would issue an extra pulse, or would still show a page on doneHead after four acknowledges. It acknowledges the receive and allocation bits, which must not clear. It also checks that the transmit-empty bit clears only once the queue holds a page, and that the completion queue pops one entry per acknowledge, so a design with purely sticky or purely level bits shows the wrong byte.

// File: rtl/pkt_page_pkg.sv
package pkt_page_pkg;

  typedef enum logic [2:0] {
    CMD_NOP         = 3'd0,
    CMD_ALLOC_TX    = 3'd1,
    CMD_RESET       = 3'd2,
    CMD_RX_POP      = 3'd3,
    CMD_RX_POP_FREE = 3'd4,
    CMD_FREE        = 3'd5,
    CMD_TX_PUSH     = 3'd6,
    CMD_TX_CLEAR    = 3'd7
  } cmdCode_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic allocTx;
    logic retry;
    logic resetAll;
    logic rxGrant;
    logic rxPop;
    logic rxFree;
    logic relPkt;
    logic txPush;
    logic txClear;
    logic txIssue;
    logic donePop;
  } ctrlStrobes_t;

  localparam logic [7:0] EMPTY_CODE = 8'h80;
  localparam logic [7:0] ACK_MASK   = 8'hD6;
  localparam int INT_RX      = 0;
  localparam int INT_TXDONE  = 1;
  localparam int INT_TXEMPTY = 2;
  localparam int INT_ALLOC   = 3;

endpackage

// File: rtl/pkt_page_fifo.sv
module pkt_page_fifo #(
  parameter int DEPTH = 4,
  parameter int W = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] countNxt
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  function automatic logic [PW-1:0] stepPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign head   = mem[rdPtr];
  assign countNxt = clr ? '0 : count + CW'(doPush) - CW'(doPop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      count <= countNxt;
      if (clr) begin
        rdPtr <= '0;
        wrPtr <= '0;
      end else begin
        if (doPush) wrPtr <= stepPtr(wrPtr);
        if (doPop)  rdPtr <= stepPtr(rdPtr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/pkt_page_ctrl.sv
module pkt_page_ctrl
  import pkt_page_pkg::*;
(
  input  logic         cmdValid,
  input  logic [2:0]   cmdCode,
  input  logic         allocPending,
  input  logic         anyFree,
  input  logic         txEmpty,
  input  logic         rxFull,
  input  logic         rxAllocReq,
  input  logic         txEnable,
  input  logic         ackValid,
  input  logic         ackDone,
  output ctrlStrobes_t strb
);
  cmdCode_e code;
  assign code = cmdCode_e'(cmdCode);

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      unique case (code)
        CMD_ALLOC_TX:    strb.allocTx  = 1'b1;
        CMD_RESET:       strb.resetAll = 1'b1;
        CMD_RX_POP:      strb.rxPop    = 1'b1;
        CMD_RX_POP_FREE: strb.rxFree   = 1'b1;
        CMD_FREE:        strb.relPkt   = 1'b1;
        CMD_TX_PUSH:     strb.txPush   = 1'b1;
        CMD_TX_CLEAR:    strb.txClear  = 1'b1;
        default:         ;
      endcase
    end
    strb.txIssue = txEnable & ~txEmpty &
                   ~(cmdValid & ((code == CMD_RESET) | (code == CMD_TX_CLEAR)));
    // a pending transmit allocation outranks the receive side
    strb.retry   = ~cmdValid & allocPending & anyFree;
    strb.rxGrant = ~cmdValid & ~strb.retry & rxAllocReq & anyFree & ~rxFull;
    strb.donePop = ackValid & ackDone;
  end
endmodule

// File: rtl/pkt_page_dp.sv
module pkt_page_dp
  import pkt_page_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int CNT_W = $clog2(NUM_PAGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [PAGE_W-1:0] pktNum,
  input  logic              autoRelease,
  input  logic              ackValid,
  input  logic [7:0]        ackData,
  input  logic              maskWe,
  input  logic [7:0]        maskData,
  output logic [7:0]        allocResult,
  output logic [7:0]        doneHead,
  output logic [7:0]        rxHead,
  output logic [CNT_W-1:0]  usedPages,
  output logic [7:0]        intStatus,
  output logic [7:0]        intMask,
  output logic              txStart,
  output logic [PAGE_W-1:0] txPage,
  output logic              anyFree,
  output logic              allocPending,
  output logic              txEmpty,
  output logic              rxFull
);
  logic [NUM_PAGES-1:0] bitmap, relMask, setMask;
  logic [PAGE_W-1:0]    lowIdx, txHeadIdx, doneHeadIdx, rxHeadIdx;
  logic                 doneEmpty, rxEmpty, txFullUnused, doneFullUnused;
  logic [CNT_W-1:0]     txCntNxt, doneCntNxt, rxCntNxt;
  logic [7:0]           statusNxt;

  function automatic logic [NUM_PAGES-1:0] oneHot(input logic [PAGE_W-1:0] i);
    return NUM_PAGES'(1) << i;
  endfunction

  pkt_page_fifo #(.DEPTH(NUM_PAGES), .W(PAGE_W)) txQ (
    .clk, .rstN, .clr(strb.resetAll | strb.txClear), .push(strb.txPush),
    .pop(strb.txIssue), .din(pktNum), .head(txHeadIdx), .empty(txEmpty),
    .full(txFullUnused), .countNxt(txCntNxt));

  pkt_page_fifo #(.DEPTH(NUM_PAGES), .W(PAGE_W)) doneQ (
    .clk, .rstN, .clr(strb.resetAll | strb.txClear),
    .push(strb.txIssue & ~autoRelease), .pop(strb.donePop), .din(txHeadIdx),
    .head(doneHeadIdx), .empty(doneEmpty), .full(doneFullUnused),
    .countNxt(doneCntNxt));

  pkt_page_fifo #(.DEPTH(NUM_PAGES), .W(PAGE_W)) rxQ (
    .clk, .rstN, .clr(strb.resetAll), .push(strb.rxGrant),
    .pop(strb.rxPop | strb.rxFree), .din(lowIdx), .head(rxHeadIdx),
    .empty(rxEmpty), .full(rxFull), .countNxt(rxCntNxt));

  // lowest free page and occupancy
  always_comb begin
    lowIdx = '0;
    usedPages = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!bitmap[i]) lowIdx = PAGE_W'(i);
    end
    for (int i = 0; i < NUM_PAGES; i++) usedPages += CNT_W'(bitmap[i]);
  end
  assign anyFree = ~&bitmap;

  assign relMask = (strb.relPkt ? oneHot(pktNum) : '0)
                 | ((strb.rxFree & ~rxEmpty) ? oneHot(rxHeadIdx) : '0)
                 | ((strb.txIssue & autoRelease) ? oneHot(txHeadIdx) : '0);
  assign setMask = (((strb.allocTx & anyFree) | strb.retry | strb.rxGrant))
                 ? oneHot(lowIdx) : '0;

  always_comb begin
    statusNxt = intStatus;
    if (ackValid) statusNxt = statusNxt & ~(ackData & ACK_MASK);
    if (strb.allocTx) statusNxt[INT_ALLOC] = 1'b0;
    if ((strb.allocTx & anyFree) | strb.retry) statusNxt[INT_ALLOC] = 1'b1;
    if (strb.rxGrant) statusNxt[INT_RX] = 1'b1;
    if (strb.rxPop | strb.rxFree) statusNxt[INT_RX] = (rxCntNxt != '0);
    if (txCntNxt == '0) statusNxt[INT_TXEMPTY] = 1'b1;
    if (doneCntNxt != '0) statusNxt[INT_TXDONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitmap       <= '0;
      allocResult  <= '0;
      allocPending <= 1'b0;
      intStatus    <= 8'h04;
      intMask      <= '0;
      txStart      <= 1'b0;
      txPage       <= '0;
    end else begin
      bitmap    <= strb.resetAll ? '0 : ((bitmap & ~relMask) | setMask);
      intStatus <= statusNxt;
      txStart   <= strb.txIssue;
      if (strb.txIssue) txPage <= txHeadIdx;
      if (maskWe) intMask <= maskData;
      if (strb.resetAll) begin
        allocResult  <= '0;
        allocPending <= 1'b0;
      end else if (strb.allocTx) begin
        allocResult  <= anyFree ? 8'(lowIdx) : EMPTY_CODE;
        allocPending <= ~anyFree;
      end else if (strb.retry) begin
        allocResult  <= 8'(lowIdx);
        allocPending <= 1'b0;
      end
    end
  end

  assign doneHead = doneEmpty ? EMPTY_CODE : 8'(doneHeadIdx);
  assign rxHead   = rxEmpty ? EMPTY_CODE : 8'(rxHeadIdx);
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
  import pkt_page_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int CNT_W = $clog2(NUM_PAGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic [PAGE_W-1:0] pktNum,
  input  logic              rxAllocReq,
  output logic              rxAccept,
  input  logic              txEnable,
  input  logic              autoRelease,
  input  logic              ackValid,
  input  logic [7:0]        ackData,
  input  logic              maskWe,
  input  logic [7:0]        maskData,
  output logic [7:0]        allocResult,
  output logic [7:0]        doneHead,
  output logic [7:0]        rxHead,
  output logic [CNT_W-1:0]  usedPages,
  output logic [7:0]        intStatus,
  output logic [7:0]        intMask,
  output logic              irq,
  output logic              txStart,
  output logic [PAGE_W-1:0] txPage
);
  ctrlStrobes_t strb;
  logic anyFree, allocPending, txEmpty, rxFull;

  pkt_page_ctrl ctrl_i (
    .cmdValid, .cmdCode, .allocPending, .anyFree, .txEmpty, .rxFull,
    .rxAllocReq, .txEnable, .ackValid, .ackDone(ackData[INT_TXDONE]), .strb);

  pkt_page_dp #(.NUM_PAGES(NUM_PAGES)) dp_i (
    .clk, .rstN, .strb, .pktNum, .autoRelease, .ackValid, .ackData, .maskWe,
    .maskData, .allocResult, .doneHead, .rxHead, .usedPages, .intStatus,
    .intMask, .txStart, .txPage, .anyFree, .allocPending, .txEmpty, .rxFull);

  assign rxAccept = strb.rxGrant;
  assign irq = |(intStatus & intMask);
endmodule

// File: rtl/pkt_page_chk.sv
module pkt_page_chk #(
  parameter int NUM_PAGES = 4,
  localparam int CNT_W = $clog2(NUM_PAGES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdCode,
  input logic             ackValid,
  input logic [7:0]       ackData,
  input logic             txEnable,
  input logic             txStart,
  input logic [7:0]       allocResult,
  input logic [7:0]       doneHead,
  input logic [7:0]       rxHead,
  input logic [CNT_W-1:0] usedPages,
  input logic [7:0]       intStatus
);
  AST_ALLOC_OK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd1 && usedPages < CNT_W'(NUM_PAGES))
    |=> (!allocResult[7] && intStatus[3])); // R2

  AST_FULL_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd1 && usedPages == CNT_W'(NUM_PAGES))
    |=> (allocResult == 8'h80 && !intStatus[3])); // R3

  AST_RESET_MMU: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd2)
    |=> (usedPages == '0 && rxHead == 8'h80 && doneHead == 8'h80 && allocResult == 8'h00)); // R4

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(txEnable)); // R8

  AST_CLEAR_QUEUES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd7) |=> (intStatus[2] && doneHead == 8'h80)); // R10

  AST_DONE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (doneHead != 8'h80) |-> intStatus[1]); // R11

  AST_RX_NOT_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && intStatus[0] && !(cmdValid && (cmdCode == 3'd3 || cmdCode == 3'd4)))
    |=> intStatus[0]); // R12
endmodule

bind pkt_page_mgr pkt_page_chk #(.NUM_PAGES(NUM_PAGES)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .ackValid(ackValid), .ackData(ackData), .txEnable(txEnable),
  .txStart(txStart), .allocResult(allocResult), .doneHead(doneHead),
  .rxHead(rxHead), .usedPages(usedPages), .intStatus(intStatus));

// File: tb/pkt_page_mgr_tb_top.sv
module pkt_page_mgr_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, rxAllocReq = 0, txEnable = 0, autoRelease = 0;
  logic ackValid = 0, maskWe = 0;
  logic [2:0] cmdCode = '0;
  logic [1:0] pktNum = '0;
  logic [7:0] ackData = '0, maskData = '0;
  logic rxAccept, irq, txStart;
  logic [7:0] allocResult, doneHead, rxHead, intStatus, intMask;
  logic [2:0] usedPages;
  logic [1:0] txPage;
  int errs = 0, nChk = 0;
  logic [1:0] expQ[$];
  logic [1:0] expPage;
  logic acc;

  always #10 clk = ~clk;

  pkt_page_mgr dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] c, logic [1:0] p = 2'd0);
    @(negedge clk); cmdValid = 1; cmdCode = c; pktNum = p;
    @(negedge clk); cmdValid = 0;
  endtask

  task automatic txQueue(logic [1:0] p, bit expectIssue);
    if (expectIssue) expQ.push_back(p);
    cmd(3'd6, p);
  endtask

  task automatic ack(logic [7:0] d);
    @(negedge clk); ackValid = 1; ackData = d;
    @(negedge clk); ackValid = 0;
  endtask

  task automatic maskWrite(logic [7:0] d);
    @(negedge clk); maskWe = 1; maskData = d;
    @(negedge clk); maskWe = 0;
  endtask

  task automatic rxReq(output logic a);
    @(negedge clk); rxAllocReq = 1; #2 a = rxAccept;
    @(negedge clk); rxAllocReq = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor for transmit start pulses
  always @(negedge clk) begin
    if (rstN && txStart) begin
      nChk++;
      if (expQ.size() == 0) begin
        errs++;
        $display("FAIL R8: actual unexpected start page %0d expected none", txPage);
      end else begin
        expPage = expQ.pop_front();
        if (txPage !== expPage) begin
          errs++;
          $display("FAIL R8: actual page %0d expected %0d", txPage, expPage);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; nChk++;
    $display("FAIL R8 watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errs, nChk);
    $finish;
  end

  initial begin
    idle(3); rstN = 1; idle(1);
    check("R1 used", usedPages, 0);
    check("R1 alloc", allocResult, 0);
    check("R1 heads", {doneHead, rxHead}, 16'h8080);
    check("R1 status", intStatus, 8'h04);
    check("R1 mask/irq/start", {intMask, irq, txStart}, 10'h0);

    cmd(3'd1);
    check("R2 first alloc", allocResult, 0);
    check("R2 status", intStatus, 8'h0C);
    cmd(3'd1); cmd(3'd1); cmd(3'd1);
    check("R2 lowest free", allocResult, 3);
    check("R2 used", usedPages, 4);
    cmd(3'd1);
    check("R3 full result", allocResult, 8'h80);
    check("R3 alloc bit cleared", intStatus, 8'h04);
    cmd(3'd5, 2'd2); idle(1);
    check("R3 retry result", allocResult, 2);
    check("R3 retry bit", intStatus[3], 1);
    check("R3 used after retry", usedPages, 4);

    maskWrite(8'h08);
    check("R13 irq on", irq, 1);
    ack(8'h08);
    check("R12 alloc bit not acked", intStatus[3], 1);
    maskWrite(8'h00);
    check("R13 irq off", irq, 0);

    cmd(3'd2);
    check("R4 used", usedPages, 0);
    check("R4 alloc", allocResult, 0);

    rxReq(acc); check("R5 accept 1", acc, 1);
    rxReq(acc); check("R5 accept 2", acc, 1);
    check("R5 rx head", rxHead, 0);
    check("R5 used", usedPages, 2);
    check("R5 rx bit", intStatus[0], 1);
    ack(8'h01);
    check("R12 rx bit not acked", intStatus[0], 1);
    cmd(3'd3);
    check("R6 pop head", rxHead, 1);
    check("R6 bit kept", intStatus[0], 1);
    cmd(3'd4);
    check("R6 pop free empty", rxHead, 8'h80);
    check("R6 bit cleared", intStatus[0], 0);
    check("R6 page freed", usedPages, 1);
    cmd(3'd4);
    check("R6 empty pop ignored", {rxHead, 5'(usedPages)}, {8'h80, 5'd1});

    cmd(3'd2);
    cmd(3'd1); cmd(3'd1);
    txQueue(2'd0, 1);
    check("R11 empty bit sticky", intStatus[2], 1);
    ack(8'h04);
    check("R11 empty bit acked", intStatus[2], 0);
    txQueue(2'd1, 1); txQueue(2'd2, 1); txQueue(2'd3, 1);
    txQueue(2'd0, 0);
    check("R8 nothing while disabled", expQ.size(), 4);
    @(negedge clk); txEnable = 1;
    idle(6);
    check("R7 R8 fifo order drained", expQ.size(), 0);
    check("R9 done head", doneHead, 0);
    check("R11 done and empty bits", intStatus[2:1], 2'b11);
    check("R9 pages kept", usedPages, 2);
    txQueue(2'd1, 1); idle(3);
    check("R9 full done queue head", doneHead, 0);
    ack(8'h02);
    check("R12 done pop", doneHead, 1);
    check("R11 done bit kept", intStatus[1], 1);
    ack(8'h02); ack(8'h02); ack(8'h02);
    check("R9 fifth completion dropped", doneHead, 8'h80);
    check("R12 done bit cleared", intStatus[1], 0);

    @(negedge clk); autoRelease = 1;
    txQueue(2'd0, 1); idle(3);
    check("R9 auto release frees", usedPages, 1);
    check("R9 auto release no record", doneHead, 8'h80);

    @(negedge clk); autoRelease = 0;
    txQueue(2'd3, 1); idle(3);
    check("R9 recorded", doneHead, 3);
    @(negedge clk); txEnable = 0;
    txQueue(2'd2, 0);
    cmd(3'd7);
    check("R10 done cleared", doneHead, 8'h80);
    check("R10 empty bit", intStatus[2], 1);
    @(negedge clk); txEnable = 1;
    idle(4);
    check("R10 nothing issued", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, nChk);
    $finish;
  end
endmodule